// File: doc/BRIEF.md
# Register-Driven SPI Master

This block is an SPI master that software controls through six 16-bit registers on a simple word-indexed bus. One register holds the mode bits, one drives seven slave-select lines, one is a read-only status word, and one sets the SCK divider. The other two are the byte buffers. Writing the transmit slot hands a byte to the shift engine. The engine clocks it out on MOSI while it clocks a byte in from MISO, using the clock polarity, clock phase and bit order held in the mode register.

The register bus takes a write or a read in a single cycle and never stalls, so it has no back-pressure. Read data is combinational on the selected index. A read strobe acts only on the receive slot: it clears the receive-ready flag. The serial pins and the select lines are plain levels. Software starts a transfer by writing a byte. It then polls status for the end of the shift and reads the received byte.

Top module: `spi_master_mm`

## Requirements
- R1: Register indices are 0 mode, 1 select, 2 status, 3 transmit, 4 receive and 5 divider. Mode reads back bits 5:0 and zeros above them. Select reads back bits 7:1 and 15:9, with bits 0 and 8 read as zero. The divider reads back all 16 bits. Writes to the status index are ignored.
- R2: Select bit n (1 to 7) enables output `sel_n[n-1]`, and bit n+8 gives the level that output drives when it is enabled. A disabled output drives high. A change takes effect in the cycle after the write.
- R3: SCK rests at the CPOL level (mode bit 4) whenever no byte is shifting. During a byte, consecutive SCK edges are max(D,2) system clocks apart, where D is the divider value. Each byte produces 16 SCK edges.
- R4: A transmit write is accepted only while enable (mode bit 0), master (bit 1) and start-on-write (bit 2) are all set. Any other transmit write leaves status unchanged and produces no SCK edge.
- R5: With CPHA=0 (mode bit 3 clear), the first data bit is on MOSI before the first edge, and MISO is sampled on leading edges. With CPHA=1, MOSI changes on leading edges and MISO is sampled on trailing edges. In both cases the slave sees the written byte and the master receives the slave's byte.
- R6: Mode bit 5 set sends and receives least significant bit first. Clear sends and receives most significant bit first.
- R7: Status bit 0 (transmit pending) sets on an accepted transmit write. It clears when the shift engine takes the byte.
- R8: Status bit 1 (transfer done) sets when a byte finishes shifting. It clears on the next accepted transmit write.
- R9: Status bit 2 (receive ready) sets when a byte finishes, and the receive slot then returns the byte shifted in. A read of the receive slot clears the bit.
- R10: A transmit write made while a byte is shifting sets status bit 0 and is held. It begins shifting right after the current byte with no further write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on receive slot only) |
| bus_idx | input | 3 | Register word index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_idx` (combinational) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel_n | output | 7 | Slave-select lines 1 to 7 |

## Verification
The assertions check on every cycle that SCK sits at its idle phase whenever the engine is idle. They also check that the SCK phase moves only on a divider tick, that the done pulse never overlaps a busy engine, that transmit-pending falls only when the engine takes a byte, and that receive-ready rises only after a completed shift. Other behaviour can only be shown by the bench scenarios, which run against a modelled slave. Those scenarios cover the received and transmitted bytes under every CPOL/CPHA/bit-order mix, the measured SCK edge spacing for divider values below and above 2, the held second byte of a back-to-back pair, and the ignored transmit writes.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int REG_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int NUM_SEL = 7;
  localparam int IDX_W   = 3;
  localparam int LVL_OFF = REG_W / 2;
  localparam int CTL_W   = 6;

  localparam logic [IDX_W-1:0] IDX_CTL  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_SEL  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_STAT = 3'd2;
  localparam logic [IDX_W-1:0] IDX_TX   = 3'd3;
  localparam logic [IDX_W-1:0] IDX_RX   = 3'd4;
  localparam logic [IDX_W-1:0] IDX_DIV  = 3'd5;

  // Bit 0 is the enable, bit 5 the bit order.
  typedef struct packed {
    logic lsbf;
    logic cpol;
    logic cpha;
    logic txw;
    logic master;
    logic en;
  } ctl_t;

  function automatic logic [BYTE_W-1:0] bit_rev(input logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = v[BYTE_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [IDX_W-1:0]  idx,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              busy,
  input  logic              done_p,
  input  logic [BYTE_W-1:0] rx_byte,
  output ctl_t              ctl,
  output logic [NUM_SEL-1:0] sel_en,
  output logic [NUM_SEL-1:0] sel_lvl,
  output logic [REG_W-1:0]  div,
  output logic              load,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              pend
);
  logic [BYTE_W-1:0] rxbuf_q;
  logic              done_st, rxrdy_q;
  logic              acc_tx, rd_rx;

  assign acc_tx = wr && (idx == IDX_TX) && ctl.en && ctl.master && ctl.txw;
  assign rd_rx  = rd && (idx == IDX_RX);
  assign load   = !busy && pend && ctl.en && ctl.master;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl     <= '0;
      sel_en  <= '0;
      sel_lvl <= '0;
      div     <= '0;
      tx_byte <= '0;
      rxbuf_q <= '0;
      pend    <= 1'b0;
      done_st <= 1'b0;
      rxrdy_q <= 1'b0;
    end else begin
      if (wr && idx == IDX_CTL) ctl <= ctl_t'(wdata[CTL_W-1:0]);
      if (wr && idx == IDX_DIV) div <= wdata;
      if (wr && idx == IDX_SEL) begin
        for (int i = 0; i < NUM_SEL; i++) begin
          sel_en[i]  <= wdata[i+1];
          sel_lvl[i] <= wdata[i+1+LVL_OFF];
        end
      end
      if (acc_tx) tx_byte <= wdata[BYTE_W-1:0];
      pend <= (pend && !load) || acc_tx;
      if (done_p) begin
        rxbuf_q <= rx_byte;
        done_st <= 1'b1;
        rxrdy_q <= 1'b1;
      end else begin
        if (acc_tx) done_st <= 1'b0;
        if (rd_rx)  rxrdy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (idx)
      IDX_CTL:  rdata[CTL_W-1:0] = ctl;
      IDX_SEL: begin
        for (int i = 0; i < NUM_SEL; i++) begin
          rdata[i+1]         = sel_en[i];
          rdata[i+1+LVL_OFF] = sel_lvl[i];
        end
      end
      IDX_STAT: rdata[2:0] = {rxrdy_q, done_st, pend};
      IDX_RX:   rdata[BYTE_W-1:0] = rxbuf_q;
      IDX_DIV:  rdata = div;
      default:  rdata = '0;
    endcase
  end

  // R9
  rx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxrdy_q) |-> $past(done_p));
endmodule

// File: rtl/spim_div.sv
module spim_div
  import spim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [REG_W-1:0] div,
  output logic             tick
);
  localparam logic [REG_W-1:0] MIN_DIV = REG_W'(2);
  logic [REG_W-1:0] cnt, half;

  assign half = (div < MIN_DIV) ? MIN_DIV : div;
  assign tick = run && (cnt == half - REG_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + REG_W'(1);
  end
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              cpha,
  input  logic              cpol,
  input  logic              lsbf,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic              done_p,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int EDGES = 2 * BYTE_W;
  localparam int CW    = $clog2(EDGES);
  localparam logic [CW-1:0] LAST = CW'(EDGES - 1);

  logic              ph, cpha_l, lsbf_l;
  logic [CW-1:0]     ecnt;
  logic [BYTE_W-1:0] txsh, rxsh;
  logic              lead, smp, shf;

  assign lead = !ecnt[0];
  assign smp  = lead ^ cpha_l;
  assign shf  = !smp && !(cpha_l && ecnt == '0) && !(!cpha_l && ecnt == LAST);

  assign sck     = ph ^ cpol;
  assign mosi    = txsh[BYTE_W-1];
  assign rx_byte = lsbf_l ? bit_rev(rxsh) : rxsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      ph     <= 1'b0;
      ecnt   <= '0;
      txsh   <= '0;
      rxsh   <= '0;
      cpha_l <= 1'b0;
      lsbf_l <= 1'b0;
      done_p <= 1'b0;
    end else begin
      done_p <= 1'b0;
      if (load) begin
        busy   <= 1'b1;
        ph     <= 1'b0;
        ecnt   <= '0;
        txsh   <= lsbf ? bit_rev(tx_byte) : tx_byte;
        cpha_l <= cpha;
        lsbf_l <= lsbf;
      end else if (busy && tick) begin
        ph   <= ~ph;
        ecnt <= ecnt + CW'(1);
        if (smp) rxsh <= {rxsh[BYTE_W-2:0], miso};
        if (shf) txsh <= {txsh[BYTE_W-2:0], 1'b0};
        if (ecnt == LAST) begin
          busy   <= 1'b0;
          done_p <= 1'b1;
        end
      end
    end
  end

  // R3
  idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ph == 1'b0));
  // R3
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ph));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_p |-> !busy);
endmodule

// File: rtl/spim_sel.sv
module spim_sel
  import spim_pkg::*;
(
  input  logic [NUM_SEL-1:0] en,
  input  logic [NUM_SEL-1:0] lvl,
  output logic [NUM_SEL-1:0] sel_n
);
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_line
    assign sel_n[i] = en[i] ? lvl[i] : 1'b1;
  end
endmodule

// File: rtl/spi_master_mm.sv
module spi_master_mm
  import spim_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [IDX_W-1:0]   bus_idx,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic               sck,
  output logic               mosi,
  input  logic               miso,
  output logic [NUM_SEL-1:0] sel_n
);
  ctl_t              ctl;
  logic [NUM_SEL-1:0] sel_en, sel_lvl;
  logic [REG_W-1:0]  div;
  logic              load, busy, done_p, tick, pend;
  logic [BYTE_W-1:0] tx_byte, rx_byte;

  spim_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .idx(bus_idx),
    .wdata(bus_wdata), .rdata(bus_rdata), .busy(busy), .done_p(done_p),
    .rx_byte(rx_byte), .ctl(ctl), .sel_en(sel_en), .sel_lvl(sel_lvl),
    .div(div), .load(load), .tx_byte(tx_byte), .pend(pend)
  );

  spim_div u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div), .tick(tick)
  );

  spim_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .tx_byte(tx_byte),
    .cpha(ctl.cpha), .cpol(ctl.cpol), .lsbf(ctl.lsbf), .tick(tick),
    .miso(miso), .busy(busy), .sck(sck), .mosi(mosi), .done_p(done_p),
    .rx_byte(rx_byte)
  );

  spim_sel u_sel (.en(sel_en), .lvl(sel_lvl), .sel_n(sel_n));

  // R7
  pend_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> $rose(busy));
endmodule

// File: tb/spi_master_mm_bench.sv
`timescale 1ns/1ps
module spi_master_mm_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_idx = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic sck, mosi, miso = 1'b0;
  logic [6:0] sel_n;

  always #5 clk = ~clk;

  spi_master_mm u_spi_master_mm (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .sel_n(sel_n)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // mode the slave model follows
  bit m_cpol, m_cpha, m_lsbf, armed, mon_on;
  logic [7:0] s_out [2];
  logic [7:0] s_in [2];
  int s_obit, s_ibit;
  int ecount, gap_bad, exp_gap;
  time last_t;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] i, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_idx = i; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] i, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_idx = i; #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  function automatic logic bitval(input logic [7:0] b, input int k);
    return m_lsbf ? b[k] : b[7-k];
  endfunction

  function automatic logic [6:0] exp_sel(input logic [15:0] f);
    logic [6:0] e;
    for (int i = 0; i < 7; i++) e[i] = f[i+1] ? f[i+9] : 1'b1;
    return e;
  endfunction

  task automatic capture();
    int b = s_ibit / 8, k = s_ibit % 8;
    if (b < 2) s_in[b][m_lsbf ? k : 7-k] = mosi;
    s_ibit++;
  endtask

  task automatic drive();
    if (s_obit < 16) miso = bitval(s_out[s_obit/8], s_obit % 8);
  endtask

  // slave model
  initial forever begin
    @(sck); #1;
    if (armed) begin
      if (sck != m_cpol) begin
        if (!m_cpha) capture(); else begin drive(); s_obit++; end
      end else begin
        if (!m_cpha) begin s_obit++; drive(); end else capture();
      end
    end
  end

  // SCK edge monitor
  initial forever begin
    @(sck);
    if (mon_on) begin
      if (ecount % 16 != 0 && ($time - last_t) != exp_gap) gap_bad++;
      last_t = $time;
      ecount++;
    end
  end

  task automatic setup(bit cpol, bit cpha, bit lsbf, logic [15:0] dv);
    wr(3'd0, {10'b0, lsbf, cpol, cpha, 3'b111});
    wr(3'd5, dv);
    m_cpol = cpol; m_cpha = cpha; m_lsbf = lsbf;
    exp_gap = ((dv < 2) ? 2 : int'(dv)) * 10;
    repeat (2) @(posedge clk);
    #1;
    s_obit = 0; s_ibit = 0; ecount = 0; gap_bad = 0;
    s_in[0] = '0; s_in[1] = '0;
    if (!cpha) drive();
    armed = 1; mon_on = 1;
  endtask

  task automatic wait_done(output bit ok);
    logic [15:0] s;
    ok = 0;
    for (int n = 0; n < 3000; n++) begin
      rd(3'd2, s);
      if (s[1]) begin ok = 1; return; end
    end
  endtask

  task automatic xfer(bit cpol, bit cpha, bit lsbf, logic [15:0] dv,
                      logic [7:0] txb, logic [7:0] slvb);
    logic [15:0] s;
    bit ok;
    s_out[0] = slvb; s_out[1] = 8'h00;
    setup(cpol, cpha, lsbf, dv);
    wr(3'd3, {8'h00, txb});
    rd(3'd2, s);
    chk(s[0] == 1'b1, "R7 pending after write", s[0], 1);
    chk(s[1] == 1'b0, "R8 done cleared by write", s[1], 0);
    wait_done(ok);
    chk(ok, "R8 done sets", ok, 1);
    repeat (2) @(posedge clk);
    #1;
    chk(ecount == 16, "R3 edge count", ecount, 16);
    chk(gap_bad == 0, "R3 half period", gap_bad, 0);
    chk(sck == cpol, "R3 idle level", sck, cpol);
    chk(s_in[0] == txb, lsbf ? "R6 lsb-first mosi" : "R5 mosi byte", s_in[0], txb);
    rd(3'd2, s);
    chk(s == 16'h0006, "R9 status after byte", s, 16'h0006);
    rd(3'd4, s);
    chk(s == {8'h00, slvb}, cpha ? "R5 cpha1 rx byte" : "R9 rx byte", s, slvb);
    rd(3'd2, s);
    chk(s[2] == 1'b0, "R9 rx ready cleared", s[2], 0);
    armed = 0; mon_on = 0;
  endtask

  initial begin
    logic [15:0] s, f;
    int unused;
    unused = $urandom(32'h5EED1);
    armed = 0; mon_on = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // reset state
    chk(sel_n == 7'h7f, "R2 reset selects high", sel_n, 7'h7f);
    chk(sck == 1'b0, "R3 reset sck", sck, 0);
    rd(3'd2, s); chk(s == 0, "R1 reset status", s, 0);
    rd(3'd0, s); chk(s == 0, "R1 reset mode", s, 0);

    // R4: ignored transmit writes
    wr(3'd0, 16'h0003);
    mon_on = 1; ecount = 0;
    wr(3'd3, 16'h00A5);
    repeat (40) @(posedge clk);
    rd(3'd2, s);
    chk(s == 0, "R4 no start without start-on-write", s, 0);
    chk(ecount == 0, "R4 no sck edges", ecount, 0);
    wr(3'd0, 16'h0000);
    ecount = 0;
    wr(3'd3, 16'h005A);
    repeat (40) @(posedge clk);
    rd(3'd2, s);
    chk(s == 0, "R4 disabled write ignored", s, 0);
    chk(ecount == 0, "R4 disabled no edges", ecount, 0);
    mon_on = 0;

    // R1: register readback
    wr(3'd0, 16'hFFC0); rd(3'd0, s); chk(s == 0, "R1 mode upper bits", s, 0);
    wr(3'd1, 16'hFFFF); rd(3'd1, s); chk(s == 16'hFEFE, "R1 select readback", s, 16'hFEFE);
    wr(3'd5, 16'h1234); rd(3'd5, s); chk(s == 16'h1234, "R1 divider readback", s, 16'h1234);
    wr(3'd2, 16'hFFFF); rd(3'd2, s); chk(s == 0, "R1 status write ignored", s, 0);

    // R2: select drive
    for (int n = 0; n < 8; n++) begin
      f = 16'($urandom);
      wr(3'd1, f);
      #1;
      chk(sel_n == exp_sel(f), "R2 select levels", sel_n, exp_sel(f));
    end
    wr(3'd1, 16'h0000);

    // directed corners: divider 0 and 1 act as 2, extreme bytes
    xfer(0, 0, 0, 16'd0, 8'h81, 8'h7E);
    xfer(1, 1, 1, 16'd1, 8'hFF, 8'h00);
    xfer(0, 1, 0, 16'd3, 8'h00, 8'hFF);
    xfer(1, 0, 1, 16'd2, 8'hC4, 8'h2B);

    // random mixes
    for (int n = 0; n < 12; n++) begin
      int r = $urandom;
      xfer(r[0], r[1], r[2], 16'(r[6:4] % 7), 8'($urandom), 8'($urandom));
    end

    // R10: back-to-back
    s_out[0] = 8'h3C; s_out[1] = 8'hA5;
    setup(1, 0, 0, 16'd2);
    wr(3'd3, 16'h0096);
    wr(3'd3, 16'h005A);
    rd(3'd2, s);
    chk(s[0] == 1'b1, "R10 second byte held", s[0], 1);
    for (int n = 0; n < 2000 && s_ibit < 16; n++) @(posedge clk);
    repeat (6) @(posedge clk);
    #1;
    chk(ecount == 32, "R10 both bytes clocked", ecount, 32);
    chk(s_in[0] == 8'h96, "R10 first byte", s_in[0], 8'h96);
    chk(s_in[1] == 8'h5A, "R10 second byte", s_in[1], 8'h5A);
    rd(3'd2, s);
    chk(s == 16'h0006, "R10 status after pair", s, 16'h0006);
    rd(3'd4, s);
    chk(s == 16'h00A5, "R10 last rx byte", s, 16'h00A5);
    armed = 0; mon_on = 0;

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule